// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer, 1024 words deep and 9 bits wide, with a write port and a read port on unrelated clocks. Each side has a pair of active-low enables, and a transfer happens only when both enables of that side are low. The read port drives registered data. An active-low output enable forces the data bus to zero without touching the read pointer.

Four active-low status flags report the fill level: empty and almost-empty on the read clock, full and almost-full on the write clock. Full and empty block transfers regardless of the enables. The two almost thresholds are programmable. If the second write enable is low while reset is applied, it is repurposed as a load strobe. The write data bus then loads the two thresholds in a fixed, repeating four-step order.

The pointers cross between the clocks in Gray code through two-flop synchronizers. A flag that depends on the other side's pointer therefore clears a few cycles late, but it never sets late.

Top module: `dc_flag_fifo`

## Requirements
- R1: During and after reset, empty_n and almost_empty_n are low, full_n and almost_full_n are high, rd_data is zero, and both threshold offsets are 7.
- R2: In normal mode, a word is written on a wr_clk rising edge only if wr_en_a_n and wr_en_b_n are both low and full_n is high. With either enable high, or with full_n low, nothing is written.
- R3: full_n goes low on the wr_clk edge that brings the content to 1024 words. Further writes are ignored, and those words never appear on the read side.
- R4: empty_n goes low on the rd_clk edge that reads the last word. While empty_n is low, reads are ignored and rd_data holds its value. Reads also need both rd_en_a_n and rd_en_b_n low.
- R5: Read data appears on rd_data after the rd_clk edge that accepts the read, in the order the words were written.
- R6: While out_en_n is high, rd_data is all zeros. The registered read word is shown again once out_en_n goes low.
- R7: almost_full_n is low exactly when the free space, 1024 minus the count seen on the write side, is at or below the almost-full offset.
- R8: almost_empty_n is low exactly when the count seen on the read side is at or below the almost-empty offset.
- R9: If wr_en_b_n is low at a wr_clk edge while rst_n is low, the block enters load mode. In load mode a word is written when wr_en_a_n is low and wr_en_b_n is high.
- R10: In load mode, each wr_clk edge with wr_en_a_n and wr_en_b_n both low loads one offset part and writes no FIFO word. The parts go in the order almost-empty bits 8:0 (from wr_data[8:0]), almost-empty bit 9 (from wr_data[0]), almost-full bits 8:0, almost-full bit 9, and then the order starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_clk | input | 1 | Write clock |
| wr_en_a_n | input | 1 | First write enable, active low |
| wr_en_b_n | input | 1 | Second write enable, or load strobe in load mode, active low |
| wr_data | input | 9 | Write data, or offset part when loading |
| full_n | output | 1 | Full flag, active low, write clock domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write clock domain |
| rd_clk | input | 1 | Read clock |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable, active low; high forces rd_data to zero |
| rd_data | output | 9 | Registered read data |
| empty_n | output | 1 | Empty flag, active low, read clock domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read clock domain |

## Verification
The assertions assume that reset is held across at least two write clock edges, so that the mode is captured. They also assume that the inputs are settled around the rising edges of their own clocks. The almost-empty offset is used on the read side without synchronization, so the environment must load offsets only while no reads are in progress. The bench changes all inputs on falling clock edges and holds reset for four write edges. It loads the offsets while the read enables are held high, and it waits out the synchronizer delay before it checks any flag that depends on the other clock.

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int DW = 9,
  parameter int AW = 10,
  parameter int AE_INIT = 7,
  parameter int AF_INIT = 7
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic          wr_en_a_n,
  input  logic          wr_en_b_n,
  input  logic [DW-1:0] wr_data,
  output logic          full_n,
  output logic          almost_full_n,
  input  logic          rd_clk,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          almost_empty_n
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HW = AW - DW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic [AW-1:0] ae_off, af_off;
  logic [1:0]    ld_seq;
  logic          load_mode;
  logic [DW-1:0] rd_q;

  always_ff @(posedge wr_clk)
    if (!rst_n) load_mode <= !wr_en_b_n;

  // write side
  logic          wr_acc, ld_acc;
  logic [PW-1:0] wbin_nx, wgray_nx, rsync_bin, wfill_nx, wfree_nx;

  assign wr_acc    = !wr_en_a_n && (load_mode ? wr_en_b_n : !wr_en_b_n) && full_n;
  assign ld_acc    = load_mode && !wr_en_a_n && !wr_en_b_n;
  assign wbin_nx   = wbin + PW'(wr_acc);
  assign wgray_nx  = (wbin_nx >> 1) ^ wbin_nx;
  assign rsync_bin = g2b(rq2);
  assign wfill_nx  = wbin_nx - rsync_bin;
  assign wfree_nx  = PW'(DEPTH) - wfill_nx;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0;
      wgray <= '0;
      rq1 <= '0;
      rq2 <= '0;
      full_n <= 1'b1;
      almost_full_n <= 1'b1;
    end else begin
      wbin <= wbin_nx;
      wgray <= wgray_nx;
      rq1 <= rgray;
      rq2 <= rq1;
      full_n <= !(wfill_nx == PW'(DEPTH));
      almost_full_n <= !(wfree_nx <= PW'(af_off));
    end

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      ae_off <= AW'(AE_INIT);
      af_off <= AW'(AF_INIT);
      ld_seq <= '0;
    end else if (ld_acc) begin
      ld_seq <= ld_seq + 2'd1;
      case (ld_seq)
        2'd0: ae_off <= {ae_off[AW-1:DW], wr_data};
        2'd1: ae_off <= {wr_data[HW-1:0], ae_off[DW-1:0]};
        2'd2: af_off <= {af_off[AW-1:DW], wr_data};
        default: af_off <= {wr_data[HW-1:0], af_off[DW-1:0]};
      endcase
    end

  always_ff @(posedge wr_clk)
    if (wr_acc) mem[wbin[AW-1:0]] <= wr_data;

  // read side
  logic          rd_acc;
  logic [PW-1:0] rbin_nx, rgray_nx, wsync_bin, rfill_nx;

  assign rd_acc    = !rd_en_a_n && !rd_en_b_n && empty_n;
  assign rbin_nx   = rbin + PW'(rd_acc);
  assign rgray_nx  = (rbin_nx >> 1) ^ rbin_nx;
  assign wsync_bin = g2b(wq2);
  assign rfill_nx  = wsync_bin - rbin_nx;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0;
      rgray <= '0;
      wq1 <= '0;
      wq2 <= '0;
      empty_n <= 1'b0;
      almost_empty_n <= 1'b0;
      rd_q <= '0;
    end else begin
      rbin <= rbin_nx;
      rgray <= rgray_nx;
      wq1 <= wgray;
      wq2 <= wq1;
      empty_n <= !(rgray_nx == wq2);
      almost_empty_n <= !(rfill_nx <= PW'(ae_off));
      if (rd_acc) rd_q <= mem[rbin[AW-1:0]];
    end

  assign rd_data = out_en_n ? '0 : rd_q;
endmodule

module dc_flag_fifo_chk #(
  parameter int PW = 11
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          full_n,
  input logic          empty_n,
  input logic          load_mode,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rsync_bin,
  input logic [PW-1:0] wsync_bin
);
  localparam logic [PW-1:0] DEPTH = PW'(1 << (PW - 1));

  assert_no_overflow_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> wbin == $past(wbin));
  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> rbin == $past(rbin));
  assert_wr_fill_bound_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin - rsync_bin) <= DEPTH);
  assert_rd_fill_bound_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (wsync_bin - rbin) <= DEPTH);
  assert_wr_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wbin - $past(wbin)) <= PW'(1));
  assert_mode_hold_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $stable(load_mode));
endmodule

bind dc_flag_fifo dc_flag_fifo_chk #(.PW(AW + 1)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk), .full_n(full_n),
  .empty_n(empty_n), .load_mode(load_mode), .wbin(wbin), .rbin(rbin),
  .rsync_bin(rsync_bin), .wsync_bin(wsync_bin)
);

// File: tb/dc_flag_fifo_tb.sv
module dc_flag_fifo_tb;
  localparam int N = 1024;

  logic rst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en_a_n = 1'b1, wr_en_b_n = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1;
  logic out_en_n = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic full_n, almost_full_n, empty_n, almost_empty_n;
  int n_chk = 0, n_bad = 0;

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  dc_flag_fifo u_dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en_a_n(wr_en_a_n), .wr_en_b_n(wr_en_b_n),
    .wr_data(wr_data), .full_n(full_n), .almost_full_n(almost_full_n),
    .rd_clk(rd_clk), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .out_en_n(out_en_n), .rd_data(rd_data), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic ld);
    rst_n = 1'b0;
    wr_en_b_n = ~ld;
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    wr_en_b_n = 1'b1;
    @(negedge rd_clk);
  endtask

  task automatic wr_op(input logic a, input logic b, input logic [8:0] d);
    @(negedge wr_clk);
    wr_en_a_n = a; wr_en_b_n = b; wr_data = d;
    @(posedge wr_clk);
    @(negedge wr_clk);
    wr_en_a_n = 1'b1; wr_en_b_n = 1'b1;
  endtask

  task automatic rd_op(input logic a, input logic b);
    @(negedge rd_clk);
    rd_en_a_n = a; rd_en_b_n = b;
    @(posedge rd_clk);
    @(negedge rd_clk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
    @(negedge rd_clk);
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] held;
    // normal mode
    do_reset(1'b0);
    check("R1 empty_n", empty_n, 0);
    check("R1 full_n", full_n, 1);
    check("R1 almost_empty_n", almost_empty_n, 0);
    check("R1 almost_full_n", almost_full_n, 1);
    check("R1 rd_data", rd_data, 0);

    // one enable only: nothing written (R2)
    wr_op(1'b0, 1'b1, 9'h0AA);
    wr_op(1'b1, 1'b0, 9'h0BB);
    settle();
    check("R2 single enable no write", empty_n, 0);

    wr_op(1'b0, 1'b0, 9'h123);
    settle();
    check("R4 empty clears", empty_n, 1);
    check("R8 ae low at count 1", almost_empty_n, 0);
    rd_op(1'b0, 1'b1);
    check("R4 single read enable ignored", empty_n, 1);
    rd_op(1'b0, 1'b0);
    check("R5 read data", rd_data, 9'h123);
    check("R4 empty on last read", empty_n, 0);
    rd_op(1'b0, 1'b0);
    check("R4 read while empty holds data", rd_data, 9'h123);
    out_en_n = 1'b1;
    #1 check("R6 output forced zero", rd_data, 0);
    out_en_n = 1'b0;
    #1 check("R6 output restored", rd_data, 9'h123);
    settle();

    // fill sweep: full and almost-full (R3, R7)
    for (int i = 0; i < N; i++) begin
      wr_op(1'b0, 1'b0, pat(i));
      check("R3 full_n", full_n, (i + 1 == N) ? 0 : 1);
      check("R7 almost_full_n", almost_full_n, (N - (i + 1) <= 7) ? 0 : 1);
    end
    wr_op(1'b0, 1'b0, 9'h1FF);
    check("R3 full holds", full_n, 0);
    settle();
    check("R8 ae high when full", almost_empty_n, 1);

    // drain sweep: order, almost-empty, empty (R5, R8, R4)
    for (int k = 1; k <= N; k++) begin
      if (k == 500) out_en_n = 1'b1;
      rd_op(1'b0, 1'b0);
      if (k == 500) begin
        check("R6 zero while disabled", rd_data, 0);
        out_en_n = 1'b0;
        #1;
      end
      check("R5 fifo order", rd_data, pat(k - 1));
      check("R8 almost_empty_n", almost_empty_n, (N - k <= 7) ? 0 : 1);
      check("R4 empty_n", empty_n, (k == N) ? 0 : 1);
    end
    held = rd_data;
    rd_op(1'b0, 1'b0);
    check("R3 overflow word never read", rd_data, held);

    // load mode (R9, R10)
    do_reset(1'b1);
    check("R1 reset in load mode", empty_n, 0);
    wr_op(1'b0, 1'b0, 9'd20);
    wr_op(1'b0, 1'b0, 9'd0);
    wr_op(1'b0, 1'b0, 9'd5);
    wr_op(1'b0, 1'b0, 9'd0);
    settle();
    check("R10 loads write no word", empty_n, 0);
    for (int i = 0; i < 20; i++) wr_op(1'b0, 1'b1, pat(i + 3));
    settle();
    check("R9 load-mode writes land", empty_n, 1);
    check("R10 ae offset 20 at count 20", almost_empty_n, 0);
    wr_op(1'b0, 1'b1, pat(23));
    settle();
    check("R10 ae offset 20 at count 21", almost_empty_n, 1);
    check("R7 af high at count 21", almost_full_n, 1);
    wr_op(1'b0, 1'b0, 9'd3);
    settle();
    check("R10 wrapped load no word", almost_empty_n, 1);
    for (int k = 1; k <= 17; k++) begin
      rd_op(1'b0, 1'b0);
      check("R9 data", rd_data, pat(k + 2));
    end
    check("R10 ae offset 3 at count 4", almost_empty_n, 1);
    rd_op(1'b0, 1'b0);
    check("R10 ae offset 3 at count 3", almost_empty_n, 0);
    check("R5 data", rd_data, pat(20));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule